// File: doc/BRIEF.md
# Fixed-Order Actor Dispatcher

This block hands actors to a single shared processor that runs one actor at a time and cannot be interrupted. The order in which actors run is held in a cyclic table that is loaded at configuration time. At run time the dispatcher decides only when the next start happens. A start is issued when the processor is idle and the actor named by the current table entry is ready. After the last valid entry, the table position returns to entry 0.

The dispatcher is deliberately not work-conserving. If the current entry's actor is not ready, the processor stays idle even while other actors are ready. An actor that must run several times per iteration is listed several times in the table.

To switch to a different use-case, the system raises a reconfigure request. The dispatcher then stops issuing starts and waits until the processor is idle. Once it has entered its quiet load state, it accepts table writes followed by a commit that sets the list length. A counter reports how many consecutive cycles the processor has been left waiting on the current entry.

Top module: `static_order_dispatch`

## Requirements
- R1: After reset, `start` is 0, `quiescent` is 1 (the block is in load state with an empty program), and `stall_cycles` is 0.
- R2: In run state with `proc_idle` high, no reconfigure request, and the ready bit of the current entry's actor high at a clock edge, `start` is 1 for exactly the following cycle, and `start_actor` carries that entry's identifier.
- R3: While the current entry's actor is not ready, no start is issued, whatever the other ready bits are.
- R4: Entries are dispatched in table order from entry 0 to entry length−1, and then again from entry 0.
- R5: An identifier that appears in several entries is dispatched once per appearance.
- R6: A start is issued only if `proc_idle` was high at the edge that issued it. At least one cycle without a start follows every start.
- R7: While `reconf_req` is high, no start is issued. Once the processor is idle, `quiescent` rises, and it stays high until a commit. No start occurs while `quiescent` is high.
- R8: A pulse on `load_we` writes `load_actor` into entry `load_addr` only while `quiescent` is high. A write in run state leaves the table unchanged.
- R9: A `load_commit` pulse in load state sets the list length from `load_len`, returns the position to entry 0, and lowers `quiescent` in the next cycle.
- R10: `stall_cycles` increases by 1 on every edge in run state at which the processor is idle and the current entry's actor is not ready. It saturates at its maximum (255 by default) and is 0 on the cycle a start is shown.
- R11: A committed length of 0 is taken as 1. A committed length above the table depth (16 by default) is taken as the table depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ready_vec | input | N_ACTORS | One ready bit per actor, indexed by identifier |
| proc_idle | input | 1 | High while the processor runs no actor |
| reconf_req | input | 1 | Request to stop dispatching and enter load state |
| load_we | input | 1 | Table write strobe |
| load_addr | input | PTR_W | Table entry to write |
| load_actor | input | ID_W | Actor identifier to write |
| load_commit | input | 1 | Ends loading and sets the length |
| load_len | input | LEN_W | Number of valid entries at commit |
| start | output | 1 | One-cycle start strobe to the processor |
| start_actor | output | ID_W | Identifier of the actor being started |
| quiescent | output | 1 | High in load state |
| stall_cycles | output | STALL_W | Consecutive idle cycles spent waiting on the current entry |

## Verification
Every result is registered. A start, a stall-count step, and the rise or fall of `quiescent` therefore appear one clock edge after the input condition that causes them. The bench changes inputs on falling edges and reads the outputs on the next falling edge after the deciding rising edge. The stall count is checked as an exact number of edges counted since the commit. The dispatch order is checked by a monitor against a queue of expected identifiers on every cycle with `start` high, so the spacing set by the processor model does not matter. A start with no expected entry is also reported.

// File: rtl/sod_pkg.sv
package sod_pkg;
    localparam int DEF_ACTORS  = 8;
    localparam int DEF_DEPTH   = 16;
    localparam int DEF_STALL_W = 8;

    typedef enum logic {
        MODE_RUN  = 1'b0,
        MODE_LOAD = 1'b1
    } sod_mode_e;

    typedef struct packed {
        logic fire;
        logic wait_cyc;
    } sod_decision_t;
endpackage

// File: rtl/sod_table.sv
module sod_table #(
    parameter int DEPTH = 16,
    parameter int ID_W  = 3,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_addr,
    input  logic [ID_W-1:0]  wr_id,
    input  logic [PTR_W-1:0] rd_addr,
    output logic [ID_W-1:0]  rd_id
);
    logic [ID_W-1:0] slots [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[g] <= '0;
            end else if (wr_en && wr_addr == PTR_W'(g)) begin
                slots[g] <= wr_id;
            end
        end
    end

    assign rd_id = slots[rd_addr];
endmodule

// File: rtl/sod_cursor.sv
module sod_cursor #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    input  logic             restart,
    input  logic [LEN_W-1:0] new_len,
    output logic [PTR_W-1:0] pos
);
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_clamped;
    logic             at_last;

    always_comb begin
        if (new_len == '0)
            len_clamped = LEN_W'(1);
        else if (new_len > LEN_W'(DEPTH))
            len_clamped = LEN_W'(DEPTH);
        else
            len_clamped = new_len;
    end

    assign at_last = ({1'b0, pos} == (len_q - LEN_W'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= LEN_W'(1);
            pos   <= '0;
        end else if (restart) begin
            len_q <= len_clamped;
            pos   <= '0;
        end else if (advance) begin
            pos <= at_last ? '0 : pos + PTR_W'(1);
        end
    end

    assert_pos_in_range_R4: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, pos} < len_q));
    assert_restart_home_R9: assert property (@(posedge clk) disable iff (rst)
        restart |=> (pos == '0));
endmodule

// File: rtl/sod_stall.sv
module sod_stall #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         waiting,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (!waiting)
            count <= '0;
        else if (count != TOP)
            count <= count + W'(1);
    end

    assert_stall_step_R10: assert property (@(posedge clk) disable iff (rst)
        (count != '0 && count != TOP && !$past(rst)) |-> (count == $past(count) + W'(1)));
    assert_stall_sat_R10: assert property (@(posedge clk) disable iff (rst)
        (waiting && count == TOP) |=> (count == TOP));
endmodule

// File: rtl/static_order_dispatch.sv
module static_order_dispatch
    import sod_pkg::*;
#(
    parameter int N_ACTORS = DEF_ACTORS,
    parameter int DEPTH    = DEF_DEPTH,
    parameter int STALL_W  = DEF_STALL_W,
    localparam int ID_W  = $clog2(N_ACTORS),
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_ACTORS-1:0] ready_vec,
    input  logic                proc_idle,
    input  logic                reconf_req,
    input  logic                load_we,
    input  logic [PTR_W-1:0]    load_addr,
    input  logic [ID_W-1:0]     load_actor,
    input  logic                load_commit,
    input  logic [LEN_W-1:0]    load_len,
    output logic                start,
    output logic [ID_W-1:0]     start_actor,
    output logic                quiescent,
    output logic [STALL_W-1:0]  stall_cycles
);
    sod_mode_e      mode_q;
    sod_decision_t  dec;
    logic [PTR_W-1:0] pos;
    logic [ID_W-1:0]  cur_id;
    logic             slot_free;
    logic             commit_now;

    assign commit_now = (mode_q == MODE_LOAD) && load_commit;

    sod_table #(.DEPTH(DEPTH), .ID_W(ID_W)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (load_we && mode_q == MODE_LOAD),
        .wr_addr (load_addr),
        .wr_id   (load_actor),
        .rd_addr (pos),
        .rd_id   (cur_id)
    );

    sod_cursor #(.DEPTH(DEPTH)) u_cursor (
        .clk     (clk),
        .rst     (rst),
        .advance (dec.fire),
        .restart (commit_now),
        .new_len (load_len),
        .pos     (pos)
    );

    // the processor may start work only if idle and no strobe is in flight
    assign slot_free = (mode_q == MODE_RUN) && !reconf_req && proc_idle && !start;

    always_comb begin
        dec.fire     = slot_free && ready_vec[cur_id];
        dec.wait_cyc = slot_free && !ready_vec[cur_id];
    end

    sod_stall #(.W(STALL_W)) u_stall (
        .clk     (clk),
        .rst     (rst),
        .waiting (dec.wait_cyc),
        .count   (stall_cycles)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= MODE_LOAD;
            start       <= 1'b0;
            start_actor <= '0;
        end else begin
            start <= dec.fire;
            if (dec.fire)
                start_actor <= cur_id;
            case (mode_q)
                MODE_RUN:  if (reconf_req && proc_idle && !start) mode_q <= MODE_LOAD;
                MODE_LOAD: if (load_commit) mode_q <= MODE_RUN;
                default:   mode_q <= MODE_LOAD;
            endcase
        end
    end

    assign quiescent = (mode_q == MODE_LOAD);

    assert_start_after_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (start && !$past(rst)) |-> $past(proc_idle));
    assert_single_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);
    assert_quiet_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        quiescent |-> !start);
    assert_stall_clear_R10: assert property (@(posedge clk) disable iff (rst)
        start |-> (stall_cycles == '0));
    assert_commit_leaves_R9: assert property (@(posedge clk) disable iff (rst)
        (quiescent && load_commit) |=> !quiescent);
endmodule

// File: tb/static_order_dispatch_bench.sv
module static_order_dispatch_bench;
    localparam int NA = 8;
    localparam int DP = 16;
    localparam int EXEC = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NA-1:0] ready_vec = '0;
    logic proc_idle;
    logic reconf_req = 1'b0;
    logic load_we = 1'b0;
    logic [3:0] load_addr = '0;
    logic [2:0] load_actor = '0;
    logic load_commit = 1'b0;
    logic [4:0] load_len = '0;
    logic start;
    logic [2:0] start_actor;
    logic quiescent;
    logic [7:0] stall_cycles;

    int checks = 0;
    int errors = 0;
    int busy = 0;
    int mirror [DP];
    int exp_q [$];

    always #5 clk = ~clk;

    static_order_dispatch u_static_order_dispatch (
        .clk(clk), .rst(rst), .ready_vec(ready_vec), .proc_idle(proc_idle),
        .reconf_req(reconf_req), .load_we(load_we), .load_addr(load_addr),
        .load_actor(load_actor), .load_commit(load_commit), .load_len(load_len),
        .start(start), .start_actor(start_actor), .quiescent(quiescent),
        .stall_cycles(stall_cycles)
    );

    // processor model: busy for EXEC cycles after a start
    always @(posedge clk) begin
        if (rst) busy <= 0;
        else if (start) busy <= EXEC;
        else if (busy != 0) busy <= busy - 1;
    end
    assign proc_idle = (busy == 0);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: compare every start against the scoreboard
    always @(negedge clk) begin
        if (!rst && start) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected start", int'(start_actor), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                check(int'(start_actor) == e, "R4 dispatch order", int'(start_actor), e);
            end
        end
    end

    task automatic write_entry(input int a, input int id);
        load_we = 1'b1; load_addr = 4'(a); load_actor = 3'(id);
        @(negedge clk);
        load_we = 1'b0;
    endtask

    task automatic commit(input int len);
        load_commit = 1'b1; load_len = 5'(len);
        @(negedge clk);
        load_commit = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic enter_load();
        ready_vec = '0;
        reconf_req = 1'b1;
        while (!quiescent) @(negedge clk);
        reconf_req = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DP; i++) mirror[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(start == 1'b0, "R1 start", int'(start), 0);
        check(quiescent == 1'b1, "R1 quiescent", int'(quiescent), 1);
        check(stall_cycles == 0, "R1 stall", int'(stall_cycles), 0);

        // R7: no start in load state even with everything ready
        ready_vec = '1;
        repeat (5) @(negedge clk);
        check(quiescent == 1'b1, "R7 stays quiet", int'(quiescent), 1);

        // R5 repeated identifiers in table
        write_entry(0, 3); mirror[0] = 3;
        write_entry(1, 1); mirror[1] = 1;
        write_entry(2, 3); mirror[2] = 3;
        write_entry(3, 6); mirror[3] = 6;
        ready_vec = 8'hFF & ~8'h08;
        commit(4);
        check(quiescent == 1'b0, "R9 run after commit", int'(quiescent), 0);

        // R3 entry 0 (actor 3) not ready, others ready: stall
        repeat (8) @(negedge clk);
        check(stall_cycles == 8, "R10 stall count", int'(stall_cycles), 8);
        check(start == 1'b0, "R3 blocked", int'(start), 0);

        // R2 dispatch one edge after ready
        for (int k = 0; k < 2; k++) begin
            exp_q.push_back(3); exp_q.push_back(1);
            exp_q.push_back(3); exp_q.push_back(6);
        end
        ready_vec = '1;
        @(negedge clk);
        check(start == 1'b1, "R2 start latency", int'(start), 1);
        check(start_actor == 3'd3, "R2 actor", int'(start_actor), 3);
        check(stall_cycles == 0, "R10 cleared on start", int'(stall_cycles), 0);
        // R8: write while running is ignored
        write_entry(1, 0);
        drain();
        check(quiescent == 1'b0, "R8 still running", int'(quiescent), 0);

        // R7 reconfigure while busy
        ready_vec = '0;
        reconf_req = 1'b1;
        check(proc_idle == 1'b0 && quiescent == 1'b0, "R7 waits for idle", int'(quiescent), 0);
        while (!quiescent) @(negedge clk);
        check(proc_idle == 1'b1, "R7 idle on entry", int'(proc_idle), 1);
        reconf_req = 1'b0;

        // R11 length 0 taken as 1
        write_entry(0, 4); mirror[0] = 4;
        write_entry(1, 5); mirror[1] = 5;
        commit(0);
        for (int k = 0; k < 3; k++) exp_q.push_back(4);
        ready_vec = '1;
        drain();
        enter_load();
        check(quiescent == 1'b1, "R7 quiet", int'(quiescent), 1);

        // R11 length above depth taken as depth; R4 wrap
        commit(20);
        for (int k = 0; k < DP + 2; k++) exp_q.push_back(mirror[k % DP]);
        ready_vec = '1;
        drain();
        enter_load();

        // R10 saturation
        write_entry(0, 7);
        commit(1);
        repeat (300) @(negedge clk);
        check(stall_cycles == 8'd255, "R10 saturate", int'(stall_cycles), 255);
        check(exp_q.size() == 0, "R4 all dispatched", exp_q.size(), 0);
        finish_run();
    end
endmodule